// File: doc/BRIEF.md
# Privileged System-Register Write Gate

This block decides the fate of every attempted write to the register that software uses to raise inter-processor software interrupts. Each attempt comes with a single-cycle strobe, the current privilege level (0 to 3) and a snapshot of the machine state that governs the access: whether the hypervisor level (level 2) is enabled, whether the secure-monitor level (level 3) is implemented, the register width each of those levels runs at, whether the processor is in monitor mode, three per-level enables for the register interface, and the trap and routing controls of the hypervisor and the secure monitor.

The gate walks a fixed priority chain, which is different for each privilege level. The first condition that matches selects one of six outcomes, and the result is presented one-hot one cycle after the strobe. The six outcomes are: commit, undefined, hypervisor trap in 64-bit form, hypervisor trap in 32-bit form, level-3 trap in 64-bit form, and monitor trap. On a commit the gate also pulses a write enable and presents the joined 64-bit value. On any trap it reports exception class 0x03. Taking the exception is left to the logic downstream.

Top module: `sysreg_wr_gate`

## Requirements
- R1: A write at privilege level 0 always yields the undefined outcome, whatever the other inputs are.
- R2: At level 1 the conditions are tried in this order, and the first match wins: coprocessor-register trap, level-1 interface enable low (undefined), hypervisor common trap, FIQ routing to hypervisor, IRQ routing to hypervisor, level-3 routing of both IRQ and FIQ. When none matches, the write commits.
- R3: A hypervisor-level condition counts only when level 2 is enabled. It gives the 64-bit hypervisor trap (outcome bit 2) if level 2 runs 64-bit, and the 32-bit hypervisor trap (bit 3) otherwise.
- R4: The level-3 routing condition needs level 3 to be implemented and both of its IRQ and FIQ routing bits set. It gives the 64-bit level-3 trap (bit 4) when level 3 runs 64-bit, and the monitor trap (bit 5) when it runs 32-bit.
- R5: At level 1 a monitor trap is suppressed while monitor mode is active, and the write falls through to commit.
- R6: At level 2 the write is undefined if the level-2 interface enable is low. Otherwise the level-3 routing condition applies, with no monitor-mode exemption. Otherwise the write commits. Hypervisor trap controls have no effect at this level.
- R7: At level 3 the write is undefined if the level-3 interface enable is low, and commits otherwise. All trap and routing controls are ignored.
- R8: A commit pulses the write enable for one cycle, together with data equal to {high source, low source}. The data output holds its value until the next commit.
- R9: The class output reads 0x03 in the cycle that any trap outcome (bits 2 to 5) is shown, and 0 otherwise.
- R10: The outcome vector (bit 0 commit, bit 1 undefined, bits 2 to 5 as above) shows exactly one set bit in the cycle after a strobe, and is all zero in any cycle that does not follow a strobe.
- R11: During and right after reset, the outcome, the write enable, the data and the class all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Write-attempt strobe, one cycle per attempt |
| priv_lvl | input | 2 | Current privilege level |
| lvl2_en | input | 1 | Hypervisor level enabled |
| lvl2_is64 | input | 1 | Hypervisor level runs 64-bit |
| lvl3_impl | input | 1 | Secure-monitor level implemented |
| lvl3_is64 | input | 1 | Secure-monitor level runs 64-bit |
| in_monitor | input | 1 | Current mode is monitor mode |
| sre_l1 | input | 1 | Level-1 register-interface enable |
| sre_l2 | input | 1 | Level-2 register-interface enable |
| sre_l3 | input | 1 | Level-3 register-interface enable |
| hyp_cpreg_trap | input | 1 | Hypervisor coprocessor-register trap |
| hyp_common_trap | input | 1 | Hypervisor common interrupt-register trap |
| hyp_fiq_route | input | 1 | FIQ routed to hypervisor |
| hyp_irq_route | input | 1 | IRQ routed to hypervisor |
| mon_irq_route | input | 1 | IRQ routed to level 3 |
| mon_fiq_route | input | 1 | FIQ routed to level 3 |
| src_lo | input | 32 | Low source word |
| src_hi | input | 32 | High source word |
| outcome | output | 6 | One-hot decision, registered |
| wr_en | output | 1 | Commit write enable pulse |
| wr_data | output | 64 | Committed value |
| trap_class | output | 6 | Exception class on trap outcomes |

## Verification
The level-1 chain is checked by switching on every condition at once and then clearing them one by one from the top. Each step shows the next link of the chain, so an error in the priority order shows up as the wrong outcome. The same hypervisor condition is run with level 2 at 64-bit, at 32-bit and disabled. This tells trap form apart from trap enabling. The level-3 routing test covers 64-bit and 32-bit mode, monitor mode on and off, and only one routing bit set, which separates R4 from R5. Levels 2 and 3 are run with every trap control set, which shows the controls that must be ignored there. The commit data and the class code are checked on every access.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int OUT_N    = 6;
  localparam int O_COMMIT = 0;
  localparam int O_UNDEF  = 1;
  localparam int O_HYP64  = 2;
  localparam int O_HYP32  = 3;
  localparam int O_L3_64  = 4;
  localparam int O_MON    = 5;
  localparam int FIRST_TRAP = O_HYP64;

  typedef logic [OUT_N-1:0] outc_t;

  localparam logic [1:0] PL_USER = 2'd0;
  localparam logic [1:0] PL_KERN = 2'd1;
  localparam logic [1:0] PL_HYP  = 2'd2;
  localparam logic [1:0] PL_MON  = 2'd3;

  function automatic outc_t sel(input int idx);
    outc_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sgw_rst_sync.sv
module sgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sgw_level_rules.sv
module sgw_level_rules
  import sgw_pkg::*;
#(
  parameter int L1_N = 6,
  parameter int L2_N = 2,
  parameter int L3_N = 1
) (
  input  logic             lvl2_en,
  input  logic             lvl2_is64,
  input  logic             lvl3_impl,
  input  logic             lvl3_is64,
  input  logic             in_monitor,
  input  logic             sre_l1,
  input  logic             sre_l2,
  input  logic             sre_l3,
  input  logic             hyp_cpreg_trap,
  input  logic             hyp_common_trap,
  input  logic             hyp_fiq_route,
  input  logic             hyp_irq_route,
  input  logic             mon_irq_route,
  input  logic             mon_fiq_route,
  output logic [L1_N-1:0]  l1_hit,
  output outc_t [L1_N-1:0] l1_code,
  output logic [L2_N-1:0]  l2_hit,
  output outc_t [L2_N-1:0] l2_code,
  output logic [L3_N-1:0]  l3_hit,
  output outc_t [L3_N-1:0] l3_code
);
  outc_t hyp_form;
  outc_t top_form;
  logic  top_route;

  always_comb begin
    hyp_form  = lvl2_is64 ? sel(O_HYP64) : sel(O_HYP32);
    top_form  = lvl3_is64 ? sel(O_L3_64) : sel(O_MON);
    top_route = lvl3_impl & mon_irq_route & mon_fiq_route;
  end

  // Level 1 chain, index 0 has the highest priority
  always_comb begin
    l1_hit[0]  = lvl2_en & hyp_cpreg_trap;
    l1_code[0] = hyp_form;
    l1_hit[1]  = ~sre_l1;
    l1_code[1] = sel(O_UNDEF);
    l1_hit[2]  = lvl2_en & hyp_common_trap;
    l1_code[2] = hyp_form;
    l1_hit[3]  = lvl2_en & hyp_fiq_route;
    l1_code[3] = hyp_form;
    l1_hit[4]  = lvl2_en & hyp_irq_route;
    l1_code[4] = hyp_form;
    l1_hit[5]  = top_route & (lvl3_is64 | ~in_monitor);
    l1_code[5] = top_form;
  end

  // Level 2 chain
  always_comb begin
    l2_hit[0]  = ~sre_l2;
    l2_code[0] = sel(O_UNDEF);
    l2_hit[1]  = top_route;
    l2_code[1] = top_form;
  end

  // Level 3 chain
  always_comb begin
    l3_hit[0]  = ~sre_l3;
    l3_code[0] = sel(O_UNDEF);
  end
endmodule

// File: rtl/sgw_prio_chain.sv
module sgw_prio_chain
  import sgw_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]  hit,
  input  outc_t [N-1:0] code,
  output outc_t         result
);
  outc_t stage [N+1];

  assign stage[N] = sel(O_COMMIT);

  generate
    for (genvar g = N - 1; g >= 0; g--) begin : g_link
      assign stage[g] = hit[g] ? code[g] : stage[g+1];
    end
  endgenerate

  assign result = stage[0];
endmodule

// File: rtl/sgw_out_stage.sv
module sgw_out_stage
  import sgw_pkg::*;
#(
  parameter int            HALF_W     = 32,
  parameter int            CLASS_W    = 6,
  parameter logic [5:0]    TRAP_CLASS = 6'h03,
  localparam int           FULL_W     = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  outc_t              dec,
  input  logic [HALF_W-1:0]  src_lo,
  input  logic [HALF_W-1:0]  src_hi,
  output outc_t              outcome,
  output logic               wr_en,
  output logic [FULL_W-1:0]  wr_data,
  output logic [CLASS_W-1:0] trap_class
);
  outc_t              out_d;
  logic               wen_d;
  logic [FULL_W-1:0]  data_d;
  logic [CLASS_W-1:0] cls_d;
  logic               is_trap;

  always_comb begin
    is_trap = |dec[OUT_N-1:FIRST_TRAP];
    out_d   = acc_valid ? dec : '0;
    wen_d   = acc_valid & dec[O_COMMIT];
    data_d  = {src_hi, src_lo};
    cls_d   = (acc_valid & is_trap) ? CLASS_W'(TRAP_CLASS) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outcome    <= '0;
      wr_en      <= 1'b0;
      trap_class <= '0;
    end else begin
      outcome    <= out_d;
      wr_en      <= wen_d;
      trap_class <= cls_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_data <= '0;
    else if (wen_d) wr_data <= data_d;
  end
endmodule

// File: rtl/sysreg_wr_gate.sv
module sysreg_wr_gate
  import sgw_pkg::*;
#(
  parameter int         HALF_W     = 32,
  parameter int         CLASS_W    = 6,
  parameter logic [5:0] TRAP_CLASS = 6'h03,
  parameter int         SYNC_STG   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [1:0]          priv_lvl,
  input  logic                lvl2_en,
  input  logic                lvl2_is64,
  input  logic                lvl3_impl,
  input  logic                lvl3_is64,
  input  logic                in_monitor,
  input  logic                sre_l1,
  input  logic                sre_l2,
  input  logic                sre_l3,
  input  logic                hyp_cpreg_trap,
  input  logic                hyp_common_trap,
  input  logic                hyp_fiq_route,
  input  logic                hyp_irq_route,
  input  logic                mon_irq_route,
  input  logic                mon_fiq_route,
  input  logic [HALF_W-1:0]   src_lo,
  input  logic [HALF_W-1:0]   src_hi,
  output logic [OUT_N-1:0]    outcome,
  output logic                wr_en,
  output logic [2*HALF_W-1:0] wr_data,
  output logic [CLASS_W-1:0]  trap_class
);
  localparam int L1_N = 6;
  localparam int L2_N = 2;
  localparam int L3_N = 1;

  logic             rst_sync_n;
  logic [L1_N-1:0]  l1_hit;
  outc_t [L1_N-1:0] l1_code;
  logic [L2_N-1:0]  l2_hit;
  outc_t [L2_N-1:0] l2_code;
  logic [L3_N-1:0]  l3_hit;
  outc_t [L3_N-1:0] l3_code;
  outc_t            l1_res, l2_res, l3_res, dec;

  sgw_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sgw_level_rules #(.L1_N(L1_N), .L2_N(L2_N), .L3_N(L3_N)) u_rules (
    .lvl2_en(lvl2_en), .lvl2_is64(lvl2_is64), .lvl3_impl(lvl3_impl),
    .lvl3_is64(lvl3_is64), .in_monitor(in_monitor),
    .sre_l1(sre_l1), .sre_l2(sre_l2), .sre_l3(sre_l3),
    .hyp_cpreg_trap(hyp_cpreg_trap), .hyp_common_trap(hyp_common_trap),
    .hyp_fiq_route(hyp_fiq_route), .hyp_irq_route(hyp_irq_route),
    .mon_irq_route(mon_irq_route), .mon_fiq_route(mon_fiq_route),
    .l1_hit(l1_hit), .l1_code(l1_code),
    .l2_hit(l2_hit), .l2_code(l2_code),
    .l3_hit(l3_hit), .l3_code(l3_code)
  );

  sgw_prio_chain #(.N(L1_N)) u_chain1 (.hit(l1_hit), .code(l1_code), .result(l1_res));
  sgw_prio_chain #(.N(L2_N)) u_chain2 (.hit(l2_hit), .code(l2_code), .result(l2_res));
  sgw_prio_chain #(.N(L3_N)) u_chain3 (.hit(l3_hit), .code(l3_code), .result(l3_res));

  always_comb begin
    unique case (priv_lvl)
      PL_USER: dec = sel(O_UNDEF);
      PL_KERN: dec = l1_res;
      PL_HYP:  dec = l2_res;
      default: dec = l3_res;
    endcase
  end

  sgw_out_stage #(.HALF_W(HALF_W), .CLASS_W(CLASS_W), .TRAP_CLASS(TRAP_CLASS)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .acc_valid(acc_valid), .dec(dec),
    .src_lo(src_lo), .src_hi(src_hi),
    .outcome(outcome), .wr_en(wr_en), .wr_data(wr_data), .trap_class(trap_class)
  );
endmodule

// File: rtl/sgw_gate_chk.sv
module sgw_gate_chk #(
  parameter int HALF_W  = 32,
  parameter int CLASS_W = 6
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                acc_valid,
  input logic [1:0]          priv_lvl,
  input logic                sre_l2,
  input logic                sre_l3,
  input logic [HALF_W-1:0]   src_lo,
  input logic [HALF_W-1:0]   src_hi,
  input logic [5:0]          outcome,
  input logic                wr_en,
  input logic [2*HALF_W-1:0] wr_data,
  input logic [CLASS_W-1:0]  trap_class
);
  logic seen;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) seen <= 1'b0;
    else             seen <= 1'b1;
  end

  p_one_hot_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && $past(acc_valid)) |-> ($countones(outcome) == 1));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && !$past(acc_valid)) |-> (outcome == '0));

  p_user_undef_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && $past(acc_valid && priv_lvl == 2'd0)) |-> outcome[1]);

  p_hyp_sre_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && $past(acc_valid && priv_lvl == 2'd2 && !sre_l2)) |-> outcome[1]);

  p_mon_level_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && $past(acc_valid && priv_lvl == 2'd3)) |-> (sre_l3 === $past(sre_l3)
      ? (outcome[0] == $past(sre_l3)) : 1'b1));

  p_commit_data_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && wr_en) |-> (outcome[0] && wr_data == {$past(src_hi), $past(src_lo)}));

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen && !wr_en) |-> $stable(wr_data));

  p_class_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|outcome[5:2]) ? (trap_class == CLASS_W'(3)) : (trap_class == '0));
endmodule

bind sysreg_wr_gate sgw_gate_chk #(.HALF_W(HALF_W), .CLASS_W(CLASS_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .acc_valid(acc_valid), .priv_lvl(priv_lvl),
  .sre_l2(sre_l2), .sre_l3(sre_l3), .src_lo(src_lo), .src_hi(src_hi),
  .outcome(outcome), .wr_en(wr_en), .wr_data(wr_data), .trap_class(trap_class)
);

// File: tb/sysreg_wr_gate_tb_top.sv
`timescale 1ns/1ps
module sysreg_wr_gate_tb_top;
  localparam int C = 0, U = 1, H64 = 2, H32 = 3, T64 = 4, MT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [1:0] priv_lvl = 2'd0;
  logic lvl2_en = 0, lvl2_is64 = 0, lvl3_impl = 0, lvl3_is64 = 0, in_monitor = 0;
  logic sre_l1 = 1, sre_l2 = 1, sre_l3 = 1;
  logic hyp_cpreg_trap = 0, hyp_common_trap = 0, hyp_fiq_route = 0, hyp_irq_route = 0;
  logic mon_irq_route = 0, mon_fiq_route = 0;
  logic [31:0] src_lo = '0, src_hi = '0;
  logic [5:0]  outcome;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [5:0]  trap_class;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysreg_wr_gate dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .priv_lvl(priv_lvl),
    .lvl2_en(lvl2_en), .lvl2_is64(lvl2_is64), .lvl3_impl(lvl3_impl),
    .lvl3_is64(lvl3_is64), .in_monitor(in_monitor),
    .sre_l1(sre_l1), .sre_l2(sre_l2), .sre_l3(sre_l3),
    .hyp_cpreg_trap(hyp_cpreg_trap), .hyp_common_trap(hyp_common_trap),
    .hyp_fiq_route(hyp_fiq_route), .hyp_irq_route(hyp_irq_route),
    .mon_irq_route(mon_irq_route), .mon_fiq_route(mon_fiq_route),
    .src_lo(src_lo), .src_hi(src_hi),
    .outcome(outcome), .wr_en(wr_en), .wr_data(wr_data), .trap_class(trap_class)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_all(input logic v);
    lvl2_en = v; lvl3_impl = v; hyp_cpreg_trap = v; hyp_common_trap = v;
    hyp_fiq_route = v; hyp_irq_route = v; mon_irq_route = v; mon_fiq_route = v;
  endtask

  task automatic baseline();
    set_all(1'b0);
    lvl2_is64 = 1; lvl3_is64 = 1; in_monitor = 0;
    sre_l1 = 1; sre_l2 = 1; sre_l3 = 1;
  endtask

  // One access; outcome is registered at the posedge after the strobe
  task automatic fire(input int exp_idx, input string req);
    logic [5:0] exp_vec;
    exp_vec = 6'b1 << exp_idx;
    src_lo = $urandom; src_hi = $urandom;
    @(negedge clk); acc_valid = 1'b1;
    @(negedge clk); acc_valid = 1'b0;
    chk(req, 64'(outcome), 64'(exp_vec));
    chk("R9", 64'(trap_class), (exp_idx >= 2) ? 64'd3 : 64'd0);
    chk("R8", 64'(wr_en), 64'(exp_idx == C));
    if (exp_idx == C) chk("R8", wr_data, {src_hi, src_lo});
    @(negedge clk);
    chk("R10", 64'(outcome), 64'd0);
  endtask

  task automatic t_reset();
    chk("R11", 64'(outcome), 64'd0);
    chk("R11", 64'(wr_en), 64'd0);
    chk("R11", wr_data, 64'd0);
    chk("R11", 64'(trap_class), 64'd0);
  endtask

  task automatic t_user();
    baseline(); set_all(1'b1); priv_lvl = 2'd0;
    fire(U, "R1");
    sre_l1 = 0; sre_l2 = 0; sre_l3 = 0;
    fire(U, "R1");
  endtask

  task automatic t_kern_order();
    baseline(); set_all(1'b1); priv_lvl = 2'd1; sre_l1 = 0;
    fire(H64, "R2");            // coprocessor trap beats enable
    hyp_cpreg_trap = 0;
    fire(U, "R2");              // enable low next
    sre_l1 = 1;
    fire(H64, "R2");            // common trap
    hyp_common_trap = 0;
    fire(H64, "R2");            // FIQ routing
    hyp_fiq_route = 0; lvl2_is64 = 0;
    fire(H32, "R3");            // IRQ routing, 32-bit form
    lvl2_en = 0;
    fire(T64, "R3");            // level 2 disabled: falls to level-3 routing
    mon_fiq_route = 0;
    fire(C, "R2");              // nothing matches
  endtask

  task automatic t_kern_top();
    baseline(); priv_lvl = 2'd1;
    lvl3_impl = 1; mon_irq_route = 1; mon_fiq_route = 1;
    fire(T64, "R4");
    lvl3_is64 = 0;
    fire(MT, "R4");
    in_monitor = 1;
    fire(C, "R5");
    lvl3_is64 = 1;
    fire(T64, "R5");            // suppression only applies to monitor trap
    in_monitor = 0; mon_irq_route = 0;
    fire(C, "R4");
    mon_irq_route = 1; lvl3_impl = 0;
    fire(C, "R4");
  endtask

  task automatic t_hyp();
    baseline(); set_all(1'b1); priv_lvl = 2'd2; sre_l2 = 0;
    fire(U, "R6");
    sre_l2 = 1; lvl3_is64 = 0; in_monitor = 1;
    fire(MT, "R6");
    lvl3_is64 = 1;
    fire(T64, "R6");
    mon_fiq_route = 0;
    fire(C, "R6");              // hypervisor traps ignored
  endtask

  task automatic t_mon();
    baseline(); set_all(1'b1); priv_lvl = 2'd3; sre_l3 = 0;
    fire(U, "R7");
    sre_l3 = 1; sre_l1 = 0; sre_l2 = 0;
    fire(C, "R7");
  endtask

  task automatic t_hold();
    logic [63:0] kept;
    baseline(); priv_lvl = 2'd3;
    fire(C, "R8");
    kept = wr_data;
    priv_lvl = 2'd0;
    fire(U, "R8");
    chk("R8", wr_data, kept);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_user();
    t_kern_order();
    t_kern_top();
    t_hyp();
    t_mon();
    t_hold();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule